// File: doc/BRIEF.md
# Prescaled Down-Counter Timer

An 8-bit timer peripheral for a small microcontroller bus. A count register that software can preset steps down by one on every output tick of a 7-bit binary prescaler. A control register picks the prescaler tap, so the divide ratio is a power of two from 1 to 128. The same register picks one of four input sources: the instruction-cycle enable, that enable gated by the timer pin, no input, or rising edges of the timer pin.

When the count steps from 1 to 0, a sticky request flag is raised. The interrupt output follows the flag unless the timer's own mask bit or the CPU's global mask input blocks it. The count keeps going past zero and wraps to 0xFF, so software can tell how many ticks have passed since the flag was raised. A control write with bit 3 set clears the prescaler, so that the next interval starts from a clean boundary.

Register access uses a one-bit address (0 = count, 1 = control), a write strobe and a read strobe. Read data is registered: it appears on the cycle after the read strobe and holds until the next read.

Top module: `pdt_timer`

## Requirements
- R1: After reset the control register reads 0x70 (flag 0, mask 1, source 11, select 0), the count register reads 0xFF and `irq` is low.
- R2: A write at address 0 loads the count register; that value is present on the next cycle.
- R3: Control bits 2:0 hold a select n. The count drops by one once every 2^n input ticks of the prescaler.
- R4: After 0x00 the count wraps to 0xFF and carries on decrementing.
- R5: Control bit 7 is the flag. It is set when a prescaler tick takes the count from 1 to 0, and it stays set until a control write places 0 in bit 7. A control write with bit 7 = 1 also sets it. If a control write and a zero-reach fall on the same edge, the written bit 7 wins.
- R6: A count write on the same edge as a zero-reach loads the written value and leaves the flag unchanged.
- R7: `irq` is high exactly when the flag is 1, control bit 6 (the mask) is 0 and `cpu_imask` is 0.
- R8: A control write with bit 3 = 1 resets the prescaler to zero. Bit 3 always reads as 0.
- R9: Source 00 (bits 5:4) gives one input tick on every cycle where `cyc_ce` is high, whatever `tmr_pin` does.
- R10: Source 01 gives an input tick on every cycle where `cyc_ce` is high and the pin, delayed through a two-flop synchronizer, is high.
- R11: Source 10 gives no input ticks, so the count only changes by writes.
- R12: Source 11 gives one input tick per rising edge of the synchronized pin and ignores `cyc_ce`.
- R13: A read strobe returns the addressed register's value from before that clock edge on `rdata` one cycle later. Reads never change the count or the prescaler.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 1 | Register select: 0 count, 1 control |
| wr | input | 1 | Write strobe |
| rd | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| cyc_ce | input | 1 | Instruction-cycle clock enable |
| tmr_pin | input | 1 | Asynchronous external timer input |
| cpu_imask | input | 1 | Global CPU interrupt mask |
| irq | output | 1 | Timer interrupt request |

## Verification
The properties assume that `wr` and `rd` are never high together, and that the address and write data are steady for the whole cycle that the strobe is high. The bench drives every strobe for exactly one cycle, with inputs changed a few nanoseconds after the rising edge. It never overlaps a read and a write. The pin is treated as asynchronous, but the bench moves it only on that same offset, so the two synchronizer flops see clean levels. The cycle-accurate reference model can then predict the exact edge on which each tick lands.

// File: rtl/pdt_pkg.sv
package pdt_pkg;
   typedef enum logic [1:0] {
      SRC_CYC   = 2'b00,
      SRC_GATED = 2'b01,
      SRC_OFF   = 2'b10,
      SRC_PIN   = 2'b11
   } src_e;

   localparam int unsigned DATA_W   = 8;
   localparam int unsigned FLAG_BIT = 7;
   localparam int unsigned MASK_BIT = 6;
   localparam int unsigned SRC_LO   = 4;
   localparam int unsigned CLR_BIT  = 3;
endpackage

// File: rtl/pdt_tick_gen.sv
module pdt_tick_gen
   import pdt_pkg::*;
#(
   parameter int unsigned SYNC_N = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cyc_ce,
   input  logic pin,
   input  src_e src,
   output logic in_tick
);
   generate
      if (SYNC_N < 2) begin : g_bad_sync
         $error("pdt_tick_gen: SYNC_N must be at least 2");
      end
   endgenerate

   logic [SYNC_N-1:0] sync_q;
   logic              prev_q;
   logic              pin_lvl;
   logic              pin_rise;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sync_q <= '0;
         prev_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[SYNC_N-2:0], pin};
         prev_q <= sync_q[SYNC_N-1];
      end
   end

   assign pin_lvl  = sync_q[SYNC_N-1];
   assign pin_rise = pin_lvl & ~prev_q;

   always_comb begin
      unique case (src)
         SRC_CYC:   in_tick = cyc_ce;
         SRC_GATED: in_tick = cyc_ce & pin_lvl;
         SRC_OFF:   in_tick = 1'b0;
         SRC_PIN:   in_tick = pin_rise;
         default:   in_tick = 1'b0;
      endcase
   end
endmodule

// File: rtl/pdt_prescaler.sv
module pdt_prescaler #(
   parameter int unsigned PRE_W = 7,
   parameter int unsigned SEL_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_tick,
   input  logic             clear,
   input  logic [SEL_W-1:0] sel,
   output logic             out_tick
);
   localparam int unsigned N_TAPS = 1 << SEL_W;

   generate
      if (PRE_W < N_TAPS - 1) begin : g_bad_pre
         $error("pdt_prescaler: PRE_W too narrow for the select range");
      end
   endgenerate

   logic [PRE_W-1:0]  pre_q;
   logic [N_TAPS-1:0] tap;

   always_ff @(posedge clk) begin
      if (!rst_n)       pre_q <= '0;
      else if (clear)   pre_q <= '0;
      else if (in_tick) pre_q <= pre_q + 1'b1;
   end

   assign tap[0] = 1'b1;
   generate
      for (genvar k = 1; k < N_TAPS; k++) begin : g_tap
         assign tap[k] = tap[k-1] & pre_q[k-1];
      end
   endgenerate

   assign out_tick = in_tick & tap[sel];
endmodule

// File: rtl/pdt_counter.sv
module pdt_counter #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             step,
   output logic [CNT_W-1:0] cnt,
   output logic             zero_hit
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   always_ff @(posedge clk) begin
      if (!rst_n)    cnt <= '1;
      else if (load) cnt <= load_val;
      else if (step) cnt <= cnt - 1'b1;
   end

   assign zero_hit = step & ~load & (cnt == ONE);
endmodule

// File: rtl/pdt_timer.sv
module pdt_timer
   import pdt_pkg::*;
#(
   parameter int unsigned CNT_W  = 8,
   parameter int unsigned PRE_W  = 7,
   parameter int unsigned SEL_W  = 3,
   parameter int unsigned SYNC_N = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                addr,
   input  logic                wr,
   input  logic                rd,
   input  logic [DATA_W-1:0]   wdata,
   output logic [DATA_W-1:0]   rdata,
   input  logic                cyc_ce,
   input  logic                tmr_pin,
   input  logic                cpu_imask,
   output logic                irq
);
   generate
      if (CNT_W > DATA_W || CNT_W < 2) begin : g_bad_cnt
         $error("pdt_timer: CNT_W must be 2..DATA_W");
      end
      if (SEL_W < 1 || SEL_W > CLR_BIT) begin : g_bad_sel
         $error("pdt_timer: SEL_W must fit below the clear bit");
      end
   endgenerate

   logic             flag_q;
   logic             mask_q;
   src_e             src_q;
   logic [SEL_W-1:0] sel_q;
   logic [CNT_W-1:0] cnt_q;
   logic             wr_cnt, wr_ctl;
   logic             in_tick, cnt_tick, zero_hit;
   logic [DATA_W-1:0] ctl_view, cnt_view;

   assign wr_cnt = wr & ~addr;
   assign wr_ctl = wr &  addr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
         mask_q <= 1'b1;
         src_q  <= SRC_PIN;
         sel_q  <= '0;
      end else if (wr_ctl) begin
         flag_q <= wdata[FLAG_BIT];
         mask_q <= wdata[MASK_BIT];
         src_q  <= src_e'(wdata[SRC_LO +: 2]);
         sel_q  <= wdata[SEL_W-1:0];
      end else if (zero_hit) begin
         flag_q <= 1'b1;
      end
   end

   pdt_tick_gen #(.SYNC_N(SYNC_N)) u_tick (
      .clk     (clk),
      .rst_n   (rst_n),
      .cyc_ce  (cyc_ce),
      .pin     (tmr_pin),
      .src     (src_q),
      .in_tick (in_tick)
   );

   pdt_prescaler #(.PRE_W(PRE_W), .SEL_W(SEL_W)) u_pre (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_tick  (in_tick),
      .clear    (wr_ctl & wdata[CLR_BIT]),
      .sel      (sel_q),
      .out_tick (cnt_tick)
   );

   pdt_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (wr_cnt),
      .load_val (wdata[CNT_W-1:0]),
      .step     (cnt_tick),
      .cnt      (cnt_q),
      .zero_hit (zero_hit)
   );

   always_comb begin
      ctl_view                 = '0;
      ctl_view[FLAG_BIT]       = flag_q;
      ctl_view[MASK_BIT]       = mask_q;
      ctl_view[SRC_LO +: 2]    = src_q;
      ctl_view[SEL_W-1:0]      = sel_q;
      cnt_view                 = '0;
      cnt_view[CNT_W-1:0]      = cnt_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)  rdata <= '0;
      else if (rd) rdata <= addr ? ctl_view : cnt_view;
   end

   assign irq = flag_q & ~mask_q & ~cpu_imask;
endmodule

// File: rtl/pdt_timer_chk.sv
module pdt_timer_chk #(
   parameter int unsigned CNT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             addr,
   input logic             wr,
   input logic             rd,
   input logic [7:0]       wdata,
   input logic [7:0]       rdata,
   input logic             cpu_imask,
   input logic             irq,
   input logic [CNT_W-1:0] cnt,
   input logic             flag,
   input logic             mask,
   input logic [1:0]       src,
   input logic             cnt_tick
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && !addr) |=> cnt == $past(wdata[CNT_W-1:0])); // R2
   AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr && !addr) |=> (cnt == $past(cnt) || cnt == $past(cnt) - ONE)); // R3
   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !(wr && addr)) |=> flag); // R5
   AST_ZERO_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_tick && cnt == ONE && !wr) |=> flag); // R5
   AST_LOAD_BLOCKS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && !addr && !flag) |=> !flag); // R6
   AST_IRQ_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (mask || cpu_imask) |-> !irq); // R7
   AST_CLR_BIT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && addr) |=> !rdata[3]); // R8
   AST_OFF_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (src == 2'b10 && !(wr && !addr)) |=> $stable(cnt)); // R11
endmodule

bind pdt_timer pdt_timer_chk #(.CNT_W(CNT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .addr      (addr),
   .wr        (wr),
   .rd        (rd),
   .wdata     (wdata),
   .rdata     (rdata),
   .cpu_imask (cpu_imask),
   .irq       (irq),
   .cnt       (cnt_q),
   .flag      (flag_q),
   .mask      (mask_q),
   .src       (src_q),
   .cnt_tick  (cnt_tick)
);

// File: tb/pdt_timer_bench.sv
`timescale 1ns/1ps
module pdt_timer_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       addr = 1'b0;
   logic       wr = 1'b0;
   logic       rd = 1'b0;
   logic [7:0] wdata = 8'h00;
   logic [7:0] rdata;
   logic       cyc_ce = 1'b1;
   logic       tmr_pin = 1'b0;
   logic       cpu_imask = 1'b0;
   logic       irq;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   pdt_timer u_pdt_timer (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr(wr), .rd(rd),
      .wdata(wdata), .rdata(rdata), .cyc_ce(cyc_ce), .tmr_pin(tmr_pin),
      .cpu_imask(cpu_imask), .irq(irq)
   );

   task automatic chk(string tag, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   // reference model: integers, one update per rising edge
   int  m_cnt, m_pre, m_flag, m_mask, m_src, m_sel;
   int  p0, p1, pp;
   int  exp_rd;
   bit  rd_pend;

   function automatic int ctl_val();
      return (m_flag << 7) | (m_mask << 6) | (m_src << 4) | m_sel;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = 255; m_pre = 0; m_flag = 0; m_mask = 1; m_src = 3; m_sel = 0;
         p0 = 0; p1 = 0; pp = 0; rd_pend = 0;
      end else begin
         int  div;
         bit  itk, otk, zero;
         case (m_src)
            0: itk = cyc_ce;
            1: itk = cyc_ce && p1 != 0;
            2: itk = 1'b0;
            default: itk = p1 != 0 && pp == 0;
         endcase
         div = 1 << m_sel;
         otk = itk && ((m_pre % div) == div - 1);
         rd_pend = rd;
         if (rd) exp_rd = addr ? ctl_val() : m_cnt;
         zero = 1'b0;
         if (wr && !addr) m_cnt = wdata;
         else if (otk) begin
            zero = (m_cnt == 1);
            m_cnt = (m_cnt + 255) % 256;
         end
         if (wr && addr && wdata[3]) m_pre = 0;
         else if (itk) m_pre = (m_pre + 1) % 128;
         if (wr && addr) begin
            m_flag = wdata[7]; m_mask = wdata[6];
            m_src = int'(wdata[5:4]); m_sel = int'(wdata[2:0]);
         end else if (zero) m_flag = 1;
         pp = p1; p1 = p0; p0 = tmr_pin;
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         chk("R7 irq vs model", irq, (m_flag != 0 && m_mask == 0 && !cpu_imask) ? 1 : 0);
         if (rd_pend) chk("R13 rdata vs model", rdata, exp_rd);
      end
   end

   task automatic cycle(int n = 1);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         #3;
      end
   endtask

   task automatic write_reg(bit a, logic [7:0] d);
      addr = a; wdata = d; wr = 1'b1;
      cycle();
      wr = 1'b0;
   endtask

   task automatic read_hand(bit a, int exp, string tag);
      addr = a; rd = 1'b1;
      cycle();
      rd = 1'b0;
      chk(tag, rdata, exp);
   endtask

   initial begin
      repeat (5) @(posedge clk);
      #3 rst_n = 1'b1;
      chk("R1 irq after reset", irq, 0);
      read_hand(1'b1, 8'h70, "R1 control reset value");
      read_hand(1'b0, 8'hFF, "R1 count reset value");

      // R2: load in source 11 with pin low (no ticks)
      write_reg(1'b0, 8'h5A);
      cycle(20);
      read_hand(1'b0, 8'h5A, "R2 count load");

      // R11: source 10, pin and enable busy, count frozen
      write_reg(1'b1, 8'h60);
      for (int i = 0; i < 30; i++) begin
         tmr_pin = ~tmr_pin;
         cycle();
      end
      read_hand(1'b0, 8'h5A, "R11 disabled source holds count");

      // R8: clear bit reads back 0
      write_reg(1'b1, 8'h68);
      read_hand(1'b1, 8'h60, "R8 clear bit reads zero");

      // R3 + R9: source 00, divide by 4, pin toggling ignored
      write_reg(1'b1, 8'h0A);
      write_reg(1'b0, 8'd20);
      for (int i = 0; i < 40; i++) begin
         tmr_pin = ~tmr_pin;
         cycle();
      end
      read_hand(1'b0, 10, "R3 R9 divide by four");

      // R5 R4 R7: run through zero
      tmr_pin = 1'b0;
      cycle(60);
      read_hand(1'b1, 8'h82, "R5 flag raised at zero");
      chk("R7 irq unmasked", irq, 1);
      cpu_imask = 1'b1;
      #1 chk("R7 irq blocked by cpu mask", irq, 0);
      cpu_imask = 1'b0;
      read_hand(1'b0, 8'hFB, "R4 wrap past zero");
      cycle(10);
      read_hand(1'b1, 8'h82, "R5 flag sticky");
      write_reg(1'b1, 8'h02);
      read_hand(1'b1, 8'h02, "R5 flag cleared by write");
      write_reg(1'b1, 8'hC2);
      read_hand(1'b1, 8'hC2, "R5 flag set by write");
      chk("R7 irq blocked by timer mask", irq, 0);

      // R6 and same-edge control write
      write_reg(1'b1, 8'h00);
      write_reg(1'b0, 8'd2);
      cycle();
      write_reg(1'b0, 8'h33);
      read_hand(1'b1, 8'h00, "R6 count write beats zero");
      write_reg(1'b0, 8'd2);
      cycle();
      write_reg(1'b1, 8'h00);
      read_hand(1'b1, 8'h00, "R5 control write beats zero");
      write_reg(1'b0, 8'd2);
      cycle(2);
      read_hand(1'b1, 8'h80, "R5 zero reach at divide by one");

      // R10: gated source
      write_reg(1'b1, 8'h10);
      cycle(3);
      write_reg(1'b0, 8'd100);
      cycle(10);
      read_hand(1'b0, 100, "R10 gate low holds");
      tmr_pin = 1'b1;
      cycle(20);
      tmr_pin = 1'b0;
      cycle(5);
      read_hand(1'b0, 80, "R10 gated pulse width");

      // R12: pin edges, enable off
      cyc_ce = 1'b0;
      write_reg(1'b1, 8'h30);
      cycle(3);
      write_reg(1'b0, 8'd50);
      for (int i = 0; i < 7; i++) begin
         tmr_pin = 1'b1; cycle(3);
         tmr_pin = 1'b0; cycle(3);
      end
      cycle(5);
      read_hand(1'b0, 43, "R12 pin edge count");
      cyc_ce = 1'b1;

      // mixed stimulus checked against the model every cycle (R13 R3 R5)
      for (int i = 0; i < 4000; i++) begin
         int r;
         r = int'($urandom_range(0, 99));
         cyc_ce    = ($urandom_range(0, 3) != 0);
         tmr_pin   = ($urandom_range(0, 2) == 0) ? ~tmr_pin : tmr_pin;
         cpu_imask = ($urandom_range(0, 9) == 0);
         addr      = $urandom_range(0, 1) != 0;
         wdata     = 8'($urandom_range(0, 255));
         if (addr) wdata[2] = 1'b0;
         wr = (r < 3);
         rd = (r >= 3 && r < 30);
         cycle();
         wr = 1'b0; rd = 1'b0;
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end
endmodule